// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds the byte-wide clock configuration of a small microcontroller. Software writes the byte over a simple bus port. The register drives several decoded controls: the source for the clock-output pin, whether peripheral clocks halt in wait mode, whether the sub-oscillator runs, whether the main oscillator is stopped, the watchdog action, and the system clock source. A read port returns the current contents. Bit 3 is not implemented and always reads as 0.

A write takes effect only while the external protect-enable input is high. An accepted write must also pass a set of interlocks. These prevent software from switching the system clock to an oscillator that is not running or not yet stable. They also prevent it from stopping the oscillator that currently clocks the system. A write that breaks any interlock is dropped as a whole and sets a sticky error flag. A dedicated clear input or reset clears that flag.

When the main oscillator is stopped, the block sends a one-cycle request that forces the main-clock divider to divide-by-8. The request is not sent while the ring oscillator is the clock in use. The watchdog action bit can only be set by software; only reset clears it.

Top module: `clkctl_reg`

## Requirements
- R1: After reset, every register bit, the error flag and the divider request are 0.
- R2: While `prot_en` is 0, a write changes nothing. This covers both the register contents and the error flag.
- R3: Bit 3 always reads as 0, whatever value is written to it. The other bits read back as they were stored.
- R4: Bit 6 (`wdt_reset_mode`, 1 = reset action, 0 = interrupt) can be set by a write. A later write of 0 leaves it at 1, and such a write is not an error.
- R5: Bit 7 (`sysclk_sub`, 1 = sub-oscillator, 0 = main oscillator) may rise only if bit 4 (`sub_osc_en`) is already 1 and `sub_stable` is 1.
- R6: Bit 7 may fall only if bit 5 (`main_stop`) is already 0 and `main_stable` is 1.
- R7: Bit 5 may rise only if bit 7 is already 1 or `ring_sel` is 1.
- R8: A write that changes bit 7 and also changes bit 4 or bit 5 is rejected.
- R9: When an accepted write makes bit 5 rise while `ring_sel` is 0, `div8_req` is 1 for exactly the next cycle. It stays 0 if `ring_sel` was 1 at the time of the write.
- R10: A rejected write leaves the register unchanged and sets `wr_err`. The flag stays set until `err_clr` is asserted or reset is applied. If a new rejection and `err_clr` occur in the same cycle, the flag stays set.
- R11: The outputs follow the stored bits. `clkout_sel` is bits 1:0, with 00 = port, 01 = sub clock, 10 = system clock/8, 11 = system clock/32. `pclk_stop_wait` is bit 2 and `sub_osc_en` is bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register contents |
| prot_en | input | 1 | Write permission |
| sub_stable | input | 1 | Sub-oscillator is stable |
| main_stable | input | 1 | Main oscillator is stable |
| ring_sel | input | 1 | Ring oscillator is the clock in use |
| err_clr | input | 1 | Clears the error flag |
| clkout_sel | output | 2 | Clock-output pin source |
| pclk_stop_wait | output | 1 | Peripheral clock halts in wait mode |
| sub_osc_en | output | 1 | Sub-oscillator enable |
| main_stop | output | 1 | Main oscillator stop |
| wdt_reset_mode | output | 1 | Watchdog action is a reset |
| sysclk_sub | output | 1 | System clock taken from the sub-oscillator |
| div8_req | output | 1 | One-cycle request to force divide-by-8 |
| wr_err | output | 1 | Sticky flag for rejected writes |

## Verification
The assertions check the following on every cycle:
- bit 3 always reads as 0;
- the watchdog bit never falls;
- every rise or fall of the clock source bit, and every rise of the stop bit, had its preconditions met one cycle earlier;
- the source bit never changes in the same step as the enable or stop bits;
- the divider request appears exactly when it should;
- the error flag stays set until it is cleared.

Some behaviour only the directed scenarios can show. These are: that a rejected write leaves the whole byte unchanged, that unprotected writes raise no error, that a clear arriving with a new rejection loses, and that each output pin carries its intended field.

// File: rtl/clkctl_reg.sv
module clkctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       prot_en,
  input  logic       sub_stable,
  input  logic       main_stable,
  input  logic       ring_sel,
  input  logic       err_clr,
  output logic [1:0] clkout_sel,
  output logic       pclk_stop_wait,
  output logic       sub_osc_en,
  output logic       main_stop,
  output logic       wdt_reset_mode,
  output logic       sysclk_sub,
  output logic       div8_req,
  output logic       wr_err
);

  logic [7:0] ctl;
  logic [7:0] nxt;
  logic       src_up, src_dn, stop_up, src_chg, side_chg;
  logic       bad, wr_ok;

  // bit 3 is unassigned; bit 6 can only be set
  assign nxt = {wr_data[7], wr_data[6] | ctl[6], wr_data[5:4],
                wr_data[3] & 1'b0, wr_data[2:0]};

  assign src_up   = ~ctl[7] &  nxt[7];
  assign src_dn   =  ctl[7] & ~nxt[7];
  assign stop_up  = ~ctl[5] &  nxt[5];
  assign src_chg  = ctl[7] ^ nxt[7];
  assign side_chg = (ctl[4] ^ nxt[4]) | (ctl[5] ^ nxt[5]);

  assign bad = (src_up  & ~(ctl[4] & sub_stable))
             | (src_dn  & ~(~ctl[5] & main_stable))
             | (stop_up & ~(ctl[7] | ring_sel))
             | (src_chg & side_chg);

  assign wr_ok = wr_en & prot_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= 8'h00;
      wr_err   <= 1'b0;
      div8_req <= 1'b0;
    end else begin
      div8_req <= wr_ok & ~bad & stop_up & ~ring_sel;
      if (wr_ok && !bad)
        ctl <= nxt;
      if (wr_ok && bad)
        wr_err <= 1'b1;
      else if (err_clr)
        wr_err <= 1'b0;
    end
  end

  assign rd_data        = ctl;
  assign clkout_sel     = ctl[1:0];
  assign pclk_stop_wait = ctl[2];
  assign sub_osc_en     = ctl[4];
  assign main_stop      = ctl[5];
  assign wdt_reset_mode = ctl[6];
  assign sysclk_sub     = ctl[7];

endmodule

// File: rtl/clkctl_reg_chk.sv
module clkctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       sub_stable,
  input logic       main_stable,
  input logic       ring_sel,
  input logic       err_clr,
  input logic       sub_osc_en,
  input logic       main_stop,
  input logic       wdt_reset_mode,
  input logic       sysclk_sub,
  input logic       div8_req,
  input logic       wr_err
);

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == 8'h00 && !wr_err && !div8_req));

  assert_bit3_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] == 1'b0);

  assert_wdt_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_mode |=> wdt_reset_mode);

  assert_src_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysclk_sub) |-> ($past(sub_osc_en) && $past(sub_stable)));

  assert_src_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysclk_sub) |-> (!$past(main_stop) && $past(main_stable)));

  assert_stop_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_stop) |-> ($past(sysclk_sub) || $past(ring_sel)));

  assert_no_combo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sysclk_sub) |-> ($stable(sub_osc_en) && $stable(main_stop)));

  assert_div8_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div8_req |-> ($rose(main_stop) && !$past(ring_sel)));

  assert_div8_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(main_stop) && !$past(ring_sel)) |-> div8_req);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !err_clr) |=> wr_err);

endmodule

bind clkctl_reg clkctl_reg_chk u_chk (.*);

// File: tb/clkctl_reg_test.sv
`timescale 1ns/1ps
module clkctl_reg_test;
  logic clk = 0, rst_n = 0, wr_en = 0, prot_en = 0;
  logic sub_stable = 0, main_stable = 0, ring_sel = 0, err_clr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [1:0] clkout_sel;
  logic pclk_stop_wait, sub_osc_en, main_stop, wdt_reset_mode, sysclk_sub, div8_req, wr_err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  clkctl_reg uut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic t_reset();
    check("R1 rd", rd_data, 8'h00);
    check("R1 err", {7'd0, wr_err}, 8'd0);
    check("R1 div8", {7'd0, div8_req}, 8'd0);
  endtask

  task automatic t_protect();
    prot_en = 0;
    wr(8'h17);
    check("R2 rd", rd_data, 8'h00);
    wr(8'h80);
    check("R2 err", {7'd0, wr_err}, 8'd0);
    prot_en = 1;
  endtask

  task automatic t_decode();
    wr(8'h0F);
    check("R3 rd", rd_data, 8'h07);
    check("R11 clkout", {6'd0, clkout_sel}, 8'd3);
    check("R11 pclk", {7'd0, pclk_stop_wait}, 8'd1);
    wr(8'h01);
    check("R11 clkout01", {6'd0, clkout_sel}, 8'd1);
    check("R11 pclk0", {7'd0, pclk_stop_wait}, 8'd0);
    wr(8'h12);
    check("R11 subosc", {7'd0, sub_osc_en}, 8'd1);
    check("R3 rd2", rd_data, 8'h12);
  endtask

  task automatic t_stop_rule();
    ring_sel = 0;
    wr(8'h32);
    check("R7 reject", rd_data, 8'h12);
    check("R10 err", {7'd0, wr_err}, 8'd1);
    clear_err();
    check("R10 clr", {7'd0, wr_err}, 8'd0);
    ring_sel = 1;
    wr(8'h32);
    check("R7 ring ok", rd_data, 8'h32);
    check("R9 no div8 on ring", {7'd0, div8_req}, 8'd0);
    wr(8'h12);
    check("R7 restore", rd_data, 8'h12);
    ring_sel = 0;
  endtask

  task automatic t_src_up();
    sub_stable = 0;
    wr(8'h92);
    check("R5 unstable", rd_data, 8'h12);
    clear_err();
    sub_stable = 1;
    wr(8'h92);
    check("R5 ok", rd_data, 8'h92);
    check("R5 no err", {7'd0, wr_err}, 8'd0);
  endtask

  task automatic t_div8();
    wr(8'hB2);
    check("R9 pulse", {7'd0, div8_req}, 8'd1);
    check("R9 rd", rd_data, 8'hB2);
    @(negedge clk);
    check("R9 one cycle", {7'd0, div8_req}, 8'd0);
  endtask

  task automatic t_src_dn();
    main_stable = 1;
    wr(8'h32);
    check("R6 main stopped", rd_data, 8'hB2);
    clear_err();
    wr(8'h92);
    check("R6 unstop", rd_data, 8'h92);
    main_stable = 0;
    wr(8'h12);
    check("R6 unstable", rd_data, 8'h92);
    clear_err();
    main_stable = 1;
    wr(8'h12);
    check("R6 ok", rd_data, 8'h12);
  endtask

  task automatic t_combo();
    wr(8'h82);
    check("R8 src+sub", rd_data, 8'h12);
    clear_err();
    wr(8'hB2);
    check("R8 src+stop", rd_data, 8'h12);
    check("R8 err", {7'd0, wr_err}, 8'd1);
    clear_err();
  endtask

  task automatic t_wdt();
    wr(8'h52);
    check("R4 set", {7'd0, wdt_reset_mode}, 8'd1);
    wr(8'h12);
    check("R4 held", rd_data, 8'h52);
    check("R4 no err", {7'd0, wr_err}, 8'd0);
  endtask

  task automatic t_err_prio();
    @(negedge clk); wr_en = 1; wr_data = 8'h72; err_clr = 1;
    @(negedge clk); wr_en = 0; err_clr = 0;
    check("R10 set wins", {7'd0, wr_err}, 8'd1);
    check("R10 unchanged", rd_data, 8'h52);
    @(negedge clk);
    check("R10 sticky", {7'd0, wr_err}, 8'd1);
    clear_err();
    check("R10 cleared", {7'd0, wr_err}, 8'd0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_protect();
    t_decode();
    t_stop_rule();
    t_src_up();
    t_div8();
    t_src_dn();
    t_combo();
    t_wdt();
    t_err_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule